// File: doc/BRIEF.md
# Inverting Bidirectional Transceiver Core

This block is the logic core of a bidirectional bus transceiver with nine data bits by default. One side is a three-state port. The other side is an open-collector bus: each bit has a pull-down enable, and a released line reads high.

Each direction has its own storage element and its own strobe input. A two-bit mode input sets the behaviour of both directions together. A direction can pass its input straight through, hold it in a transparent latch, or capture it in a rising-edge register. One mode code is asymmetric: registered toward the bus and latched toward the three-state side. Every path inverts the data.

The strobes are sampled by the core clock `clk`. The bus side sees the resolved bus level. When this device pulls a line low, that low is what the three-state side receives.

Top module: `inv_xcvr_core`

## Requirements
- R1: `mode` is decoded as {mode[1], mode[0]}. 2'b00 latches both directions. 2'b01 passes both directions straight through. 2'b10 registers both directions. 2'b11 registers toward the bus and latches toward the three-state side.
- R2: In pass-through, the logical bus level is the inverse of `a_in`. `a_out` is the inverse of the bus value as read. Both follow their inputs with no clock edge.
- R3: In latch mode, while a direction's strobe is low the output follows the input with no clock edge, and storage loads the input at each clock edge. While the strobe is high, storage holds the value it loaded at the last clock edge at which the strobe was low.
- R4: In register mode, storage loads the input at a clock edge only if the strobe is sampled high there and was sampled low at the previous edge. The output shows the inverse of storage, so a capture appears after that edge. A strobe that stays high or stays low captures nothing.
- R5: Under code 2'b11, the path toward the bus captures only on strobe rises. The path toward the three-state side is transparent while its strobe is low.
- R6: `a_oe` is high exactly when `a_drv` is high. Both storage elements keep loading or holding as usual whatever the state of either port's enables.
- R7: `b_pull[i]` is high only when `b_en_hi`=1, `b_en_lo`=0 and `pwr_ok`=1, and the logical bus level for bit i is 0. In every other case all pulls are released.
- R8: A bit with `b_float[i]`=1 is taken as logic 0 on the bus-to-A path, whatever `b_bus[i]` shows.
- R9: The bus-to-A path uses the resolved `b_bus` level, so this device's own pull-downs are seen on `a_out`.
- R10: An asynchronous active-low reset clears both storage elements to zero. Strobe history is cleared to "high", so a strobe held high through reset is not a rising edge.
- R11: After a mode change, a register or holding-latch output shows its stored value at once, and a pass-through output shows its inverted input at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Direction behaviour select (see R1) |
| strb_ab | input | 1 | Strobe for the A-to-bus path: latch enable, active low, or capture clock |
| strb_ba | input | 1 | Strobe for the bus-to-A path |
| a_in | input | W | Data arriving from the three-state side |
| a_drv | input | 1 | Three-state port drive request |
| b_en_hi | input | 1 | Bus enable, active high |
| b_en_lo | input | 1 | Bus enable, active low |
| pwr_ok | input | 1 | Power is stable; low forces the bus pulls off |
| b_bus | input | W | Resolved bus level |
| b_float | input | W | Per-bit flag marking a bus line as not driven |
| a_out | output | W | Data toward the three-state side |
| a_oe | output | 1 | Three-state drive enable |
| b_pull | output | W | Per-bit pull-down enable for the bus |

## Verification
Pass-through results, transparent-latch results, all enable effects and float masking are combinational. The bench drives inputs 2 ns after a rising edge and compares outputs 5 ns later, within the same cycle. A register capture or latch load happens at the next rising edge, so its effect is compared in the cycle after that edge. The bench's reference storage is advanced only after the compare, using the inputs that were stable at that edge. A strobe rise is judged against the strobe level sampled one edge earlier, as the design sees it.

// File: rtl/inv_xcvr_core.sv
module inv_xcvr_core #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         strb_ab,
  input  logic         strb_ba,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  input  logic         b_en_hi,
  input  logic         b_en_lo,
  input  logic         pwr_ok,
  input  logic [W-1:0] b_bus,
  input  logic [W-1:0] b_float,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_pull
);
  localparam logic [1:0] M_LATCH = 2'b00;
  localparam logic [1:0] M_THRU  = 2'b01;
  localparam logic [1:0] M_REG   = 2'b10;
  localparam logic [1:0] M_SPLIT = 2'b11;

  logic ab_thru, ab_latch, ab_reg;
  logic ba_thru, ba_latch, ba_reg;
  assign ab_thru  = (mode == M_THRU);
  assign ab_latch = (mode == M_LATCH);
  assign ab_reg   = (mode == M_REG) || (mode == M_SPLIT);
  assign ba_thru  = (mode == M_THRU);
  assign ba_latch = (mode == M_LATCH) || (mode == M_SPLIT);
  assign ba_reg   = (mode == M_REG);

  logic [W-1:0] b_seen;
  assign b_seen = b_bus & ~b_float;

  logic [W-1:0] ab_q, ba_q;
  logic         ab_prev, ba_prev;
  logic         ab_load, ba_load;

  assign ab_load = (ab_latch && !strb_ab) || (ab_reg && strb_ab && !ab_prev);
  assign ba_load = (ba_latch && !strb_ba) || (ba_reg && strb_ba && !ba_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q    <= '0;
      ba_q    <= '0;
      ab_prev <= 1'b1;
      ba_prev <= 1'b1;
    end else begin
      ab_prev <= strb_ab;
      ba_prev <= strb_ba;
      if (ab_load) ab_q <= a_in;
      if (ba_load) ba_q <= b_seen;
    end
  end

  logic [W-1:0] ab_val, ba_val;
  assign ab_val = (ab_thru || (ab_latch && !strb_ab)) ? a_in   : ab_q;
  assign ba_val = (ba_thru || (ba_latch && !strb_ba)) ? b_seen : ba_q;

  logic b_on;
  assign b_on   = b_en_hi && !b_en_lo && pwr_ok;
  assign b_pull = b_on ? ab_val : '0;
  assign a_out  = ~ba_val;
  assign a_oe   = a_drv;
endmodule

module inv_xcvr_core_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         strb_ab,
  input logic         strb_ba,
  input logic         a_drv,
  input logic         b_en_hi,
  input logic         b_en_lo,
  input logic         pwr_ok,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] b_float,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_pull
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic b_on;
  assign b_on = b_en_hi && !b_en_lo && pwr_ok;

  a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !b_on |-> (b_pull == '0));

  a_r6_a_enable: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe == a_drv);

  a_r2_thru_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (a_out == ~(b_bus & ~b_float)));

  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && mode == 2'b00 && $past(mode) == 2'b00 && strb_ab && $past(strb_ab)
     && b_on && $past(b_on)) |-> $stable(b_pull));

  a_r4_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && mode == 2'b10 && $past(mode) == 2'b10
     && !($past(strb_ba) && !$past(strb_ba, 2))) |-> $stable(a_out));
endmodule

bind inv_xcvr_core inv_xcvr_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .strb_ab(strb_ab), .strb_ba(strb_ba),
  .a_drv(a_drv), .b_en_hi(b_en_hi), .b_en_lo(b_en_lo), .pwr_ok(pwr_ok),
  .b_bus(b_bus), .b_float(b_float), .a_out(a_out), .a_oe(a_oe), .b_pull(b_pull)
);

// File: tb/sim_inv_xcvr_core.sv
module sim_inv_xcvr_core;
  localparam int W = 9;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic strb_ab = 1'b1, strb_ba = 1'b1;
  logic [W-1:0] a_in = '0;
  logic a_drv = 1'b1, b_en_hi = 1'b1, b_en_lo = 1'b0, pwr_ok = 1'b1;
  logic [W-1:0] ext_pull = '0, b_float = '0;
  logic [W-1:0] b_bus, a_out, b_pull;
  logic a_oe;

  assign b_bus = ~(b_pull | ext_pull);

  inv_xcvr_core #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .strb_ab(strb_ab), .strb_ba(strb_ba),
    .a_in(a_in), .a_drv(a_drv), .b_en_hi(b_en_hi), .b_en_lo(b_en_lo), .pwr_ok(pwr_ok),
    .b_bus(b_bus), .b_float(b_float), .a_out(a_out), .a_oe(a_oe), .b_pull(b_pull)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_pab = 1'b1, m_pba = 1'b1;

  function automatic logic [W-1:0] f_abval();
    if (mode == 2'b01 || (mode == 2'b00 && !strb_ab)) return a_in;
    return m_ab;
  endfunction
  function automatic logic f_bon();
    return b_en_hi && !b_en_lo && pwr_ok;
  endfunction
  function automatic logic [W-1:0] f_pull();
    return f_bon() ? f_abval() : '0;
  endfunction
  function automatic logic [W-1:0] f_seen();
    return ~(f_pull() | ext_pull) & ~b_float;
  endfunction
  function automatic logic [W-1:0] f_aout();
    logic ba_l;
    ba_l = (mode == 2'b00 || mode == 2'b11);
    if (mode == 2'b01 || (ba_l && !strb_ba)) return ~f_seen();
    return ~m_ba;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(tag, b_pull, f_pull());
    chk(tag, a_out, f_aout());
    chk(tag, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, a_drv});
  endtask

  task automatic model_edge();
    logic ab_l, ab_r, ba_l, ba_r;
    logic [W-1:0] s;
    s = f_seen();
    ab_l = (mode == 2'b00);
    ab_r = mode[1];
    ba_l = (mode == 2'b00 || mode == 2'b11);
    ba_r = (mode == 2'b10);
    if ((ab_l && !strb_ab) || (ab_r && strb_ab && !m_pab)) m_ab = a_in;
    if ((ba_l && !strb_ba) || (ba_r && strb_ba && !m_pba)) m_ba = s;
    m_pab = strb_ab;
    m_pba = strb_ba;
  endtask

  task automatic tick(input string tag);
    #5;
    cmp_all(tag);
    model_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=<200000", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R10: storage zero after reset
    #5;
    chk("R10", b_pull, 9'h000);
    chk("R10", a_out, 9'h1FF);
    tick("R10");
    // R2/R9: pass-through with own pulls read back
    mode = 2'b01; a_in = 9'h0A5;
    #1 chk("R2", b_pull, 9'h0A5);
    chk("R9", a_out, 9'h0A5);
    tick("R2");
    ext_pull = 9'h100;
    #1 chk("R9", a_out, 9'h1A5);
    tick("R9");
    ext_pull = '0;
    // R7: each disable combination
    b_en_lo = 1'b1;
    #1 chk("R7", b_pull, 9'h000);
    tick("R7");
    b_en_lo = 1'b0; b_en_hi = 1'b0;
    #1 chk("R7", b_pull, 9'h000);
    tick("R7");
    b_en_hi = 1'b1; pwr_ok = 1'b0;
    #1 chk("R7", b_pull, 9'h000);
    tick("R7");
    pwr_ok = 1'b1;
    // R8: floating bits read low
    b_en_hi = 1'b0; b_float = 9'h00F;
    #1 chk("R8", a_out, 9'h00F);
    tick("R8");
    b_float = '0; b_en_hi = 1'b1;
    // R3: latch transparent then hold
    mode = 2'b00; strb_ab = 1'b0; a_in = 9'h133;
    #1 chk("R3", b_pull, 9'h133);
    tick("R3");
    strb_ab = 1'b1; a_in = 9'h0CC;
    #1 chk("R3", b_pull, 9'h133);
    tick("R3");
    tick("R3");
    // R6: three-state off, storage still loads
    a_drv = 1'b0;
    #1 chk("R6", {8'h0, a_oe}, 9'h000);
    strb_ab = 1'b0;
    tick("R6");
    strb_ab = 1'b1; a_in = 9'h001;
    #1 chk("R6", b_pull, 9'h0CC);
    tick("R6");
    a_drv = 1'b1;
    // R4: register capture only on rise
    mode = 2'b10; a_in = 9'h055; strb_ab = 1'b0;
    tick("R11");
    strb_ab = 1'b1;
    tick("R4");
    #1 chk("R4", b_pull, 9'h055);
    a_in = 9'h1AA;
    tick("R4");
    #1 chk("R4", b_pull, 9'h055);
    tick("R4");
    // R5: split code
    mode = 2'b11; strb_ba = 1'b0; ext_pull = 9'h0F0; strb_ab = 1'b0;
    tick("R5");
    strb_ab = 1'b1;
    tick("R5");
    #1 chk("R5", b_pull, 9'h1AA);
    ext_pull = '0;
    // R1/R11: mode switch shows stored value at once
    mode = 2'b01;
    tick("R11");
    mode = 2'b10;
    tick("R11");
    // R1: random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) mode = 2'($urandom_range(3));
      strb_ab  = 1'($urandom_range(1));
      strb_ba  = 1'($urandom_range(1));
      a_in     = W'($urandom);
      a_drv    = 1'($urandom_range(1));
      b_en_hi  = ($urandom_range(4) != 0);
      b_en_lo  = ($urandom_range(4) == 0);
      pwr_ok   = ($urandom_range(6) != 0);
      ext_pull = ($urandom_range(2) == 0) ? W'($urandom) : '0;
      b_float  = ($urandom_range(3) == 0) ? W'($urandom) : '0;
      tick("R1");
    end
    // R10: async reset mid-run
    mode = 2'b10; strb_ab = 1'b1; strb_ba = 1'b1; b_en_hi = 1'b1; b_en_lo = 1'b0;
    pwr_ok = 1'b1; ext_pull = '0; b_float = '0;
    #1 rst_n = 1'b0;
    m_ab = '0; m_ba = '0; m_pab = 1'b1; m_pba = 1'b1;
    #1 chk("R10", b_pull, 9'h000);
    chk("R10", a_out, 9'h1FF);
    @(posedge clk);
    #2 rst_n = 1'b1;
    tick("R10");
    finish_run();
  end
endmodule